// File: doc/BRIEF.md
# Staged Brownout Supervisor

This block watches digitized voltage codes from several supply rails, one per power domain (for example the core, memory and PHY rails). Each code is compared against three falling thresholds. The highest threshold marks an early warning, the middle one a degraded condition, and the lowest one a condition that needs a reset. Each comparison has its own debounce window, so a short sag is ignored. A stage is entered only after the rail has stayed below that stage's threshold for the required number of consecutive samples.

The block keeps one system-wide stage that can only become more severe while the disturbance lasts. It returns to normal only when every rail has climbed back above the warning threshold plus a hysteresis margin. Three outputs follow from the stage:

- a request to commit logs before anything worse happens;
- a flag telling time consumers that time quality is degraded;
- a controlled reset request.

Every escalation produces a one-cycle event record carrying the rail, the new stage and a free-running timestamp, and a saturating counter counts these records. A cause register keeps the most severe rail and stage seen since software last cleared it. Per-rail minimum and maximum trackers keep the voltage extremes.

A new code is taken on every clock cycle. All thresholds, margins and windows are parameters.

Top module: `bs_supervisor`

## Requirements
- R1: While rstN is low (synchronous, active low), the three response outputs and eventValid are 0, causeStage and eventCount are 0, every railMin field is all ones and every railMax field is 0.
- R2: logFlushReq goes high at the clock edge that takes the WARN_DEB-th consecutive sample (default 3) of any one rail below WARN_LEVEL (default 200). A dip of fewer consecutive samples leaves it low.
- R3: timeDegraded goes high at the edge that takes the DEG_DEB-th consecutive sample (default 4) of a rail below DEG_LEVEL (default 180).
- R4: resetReq goes high at the edge that takes the RST_DEB-th consecutive sample (default 5) of a rail below RST_LEVEL (default 160). Whenever resetReq is high, timeDegraded and logFlushReq are high as well.
- R5: The stage never falls to a less severe non-normal value. A trip of a lower or equal stage while a higher stage is active produces no event and changes no output.
- R6: The stage stays active while any rail is below WARN_LEVEL+HYST (default 210). It returns to normal, with all three outputs low, at the first edge at which every rail is at or above that level.
- R7: Each escalation raises eventValid for exactly one cycle. The record carries eventStage (1 warn, 2 degrade, 3 reset), eventRail (the lowest-index rail among those that trip the new stage) and eventStamp (the count of clock edges since reset release before that edge).
- R8: eventCount increases by one on every escalation and saturates at all ones (255 by default).
- R9: causeStage and causeRail hold the most severe escalation since the last clear. A clearCause cycle zeroes them, unless an escalation happens in the same cycle, in which case they take that escalation.
- R10: Every clock edge out of reset folds each rail's code into that rail's railMin and railMax fields (rail r at bits r*CODE_W upward).
- R11: Debounce runs per rail. Consecutive low samples spread across different rails, none of which reaches a window on its own, trigger nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| railCode | input | NUM_RAILS*CODE_W | Rail voltage codes, rail r at bits r*CODE_W upward |
| clearCause | input | 1 | Clears the latched cause |
| logFlushReq | output | 1 | Early warning: commit logs |
| timeDegraded | output | 1 | Time quality degraded |
| resetReq | output | 1 | Controlled reset request |
| causeStage | output | 2 | Latched cause stage |
| causeRail | output | RAIL_W | Latched cause rail |
| eventValid | output | 1 | One-cycle escalation record strobe |
| eventRail | output | RAIL_W | Rail of the record |
| eventStage | output | 2 | Stage of the record |
| eventStamp | output | STAMP_W | Timestamp of the record |
| eventCount | output | CNT_W | Saturating escalation count |
| railMin | output | NUM_RAILS*CODE_W | Per-rail minimum code |
| railMax | output | NUM_RAILS*CODE_W | Per-rail maximum code |

## Verification
Rail codes change between clock edges. A stage output is due at the edge that takes the last sample of its debounce window, so the bench checks it one sample short of that edge and again at that edge. The event record, the count and the cause appear at that same edge, and eventValid is expected low one edge later. Return to normal and the min/max fields are registered and due one edge after the code that causes them, which the bench mirrors with its own per-edge model of the extremes and of the edge count.

// File: rtl/bs_pkg.sv
package bs_pkg;
  typedef enum logic [1:0] {
    STG_NORMAL  = 2'd0,
    STG_WARN    = 2'd1,
    STG_DEGRADE = 2'd2,
    STG_RESET   = 2'd3
  } stage_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   fire;
    stage_e stage;
  } evStrobe_t;
endpackage

// File: rtl/bs_datapath.sv
module bs_datapath
  import bs_pkg::*;
#(
  parameter int NUM_RAILS   = 3,
  parameter int CODE_W      = 8,
  parameter int WARN_LEVEL  = 200,
  parameter int DEG_LEVEL   = 180,
  parameter int RST_LEVEL   = 160,
  parameter int HYST        = 10,
  parameter int WARN_DEB    = 3,
  parameter int DEG_DEB     = 4,
  parameter int RST_DEB     = 5,
  parameter int STAMP_W     = 16,
  parameter int CNT_W       = 8,
  parameter int RAIL_W      = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_RAILS*CODE_W-1:0]   railCode,
  input  evStrobe_t                     evStrobe,
  input  logic [RAIL_W-1:0]             evRail,
  output logic [NUM_RAILS-1:0][1:0]     railTrip,
  output logic                          allClear,
  output logic                          eventValid,
  output logic [RAIL_W-1:0]             eventRail,
  output logic [1:0]                    eventStage,
  output logic [STAMP_W-1:0]            eventStamp,
  output logic [CNT_W-1:0]              eventCount,
  output logic [NUM_RAILS*CODE_W-1:0]   railMin,
  output logic [NUM_RAILS*CODE_W-1:0]   railMax
);
  localparam int DEB_MAX = (RST_DEB > DEG_DEB) ?
                           ((RST_DEB > WARN_DEB) ? RST_DEB : WARN_DEB) :
                           ((DEG_DEB > WARN_DEB) ? DEG_DEB : WARN_DEB);
  localparam int DEB_W   = $clog2(DEB_MAX + 1);
  localparam int CLEAR_LEVEL = WARN_LEVEL + HYST;

  function automatic int levelOf(input int s);
    case (s)
      0:       return WARN_LEVEL;
      1:       return DEG_LEVEL;
      default: return RST_LEVEL;
    endcase
  endfunction

  function automatic int windowOf(input int s);
    case (s)
      0:       return WARN_DEB;
      1:       return DEG_DEB;
      default: return RST_DEB;
    endcase
  endfunction

  logic [NUM_RAILS-1:0] railClear;
  logic [STAMP_W-1:0]   stampCnt;

  for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
    logic [CODE_W-1:0] code;
    logic [2:0]        hit;
    assign code = railCode[r*CODE_W +: CODE_W];

    for (genvar s = 0; s < 3; s++) begin : g_stage
      logic             below;
      logic [DEB_W-1:0] lowRun;
      assign below = int'(code) < levelOf(s);
      always_ff @(posedge clk) begin
        if (!rstN || !below) lowRun <= '0;
        else if (int'(lowRun) < DEB_MAX) lowRun <= lowRun + 1'b1;
      end
      assign hit[s] = below && (int'(lowRun) + 1 >= windowOf(s));
    end

    always_comb begin
      if (hit[2])      railTrip[r] = 2'd3;
      else if (hit[1]) railTrip[r] = 2'd2;
      else if (hit[0]) railTrip[r] = 2'd1;
      else             railTrip[r] = 2'd0;
    end
    assign railClear[r] = int'(code) >= CLEAR_LEVEL;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        railMin[r*CODE_W +: CODE_W] <= '1;
        railMax[r*CODE_W +: CODE_W] <= '0;
      end else begin
        if (code < railMin[r*CODE_W +: CODE_W]) railMin[r*CODE_W +: CODE_W] <= code;
        if (code > railMax[r*CODE_W +: CODE_W]) railMax[r*CODE_W +: CODE_W] <= code;
      end
    end
  end

  assign allClear = &railClear;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stampCnt   <= '0;
      eventValid <= 1'b0;
      eventRail  <= '0;
      eventStage <= 2'd0;
      eventStamp <= '0;
      eventCount <= '0;
    end else begin
      stampCnt   <= stampCnt + 1'b1;
      eventValid <= evStrobe.fire;
      if (evStrobe.fire) begin
        eventRail  <= evRail;
        eventStage <= evStrobe.stage;
        eventStamp <= stampCnt;
        if (eventCount != {CNT_W{1'b1}}) eventCount <= eventCount + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bs_control.sv
module bs_control
  import bs_pkg::*;
#(
  parameter int NUM_RAILS = 3,
  parameter int RAIL_W    = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_RAILS-1:0][1:0] railTrip,
  input  logic                      allClear,
  input  logic                      clearCause,
  output evStrobe_t                 evStrobe,
  output logic [RAIL_W-1:0]         evRail,
  output stage_e                    stage,
  output logic [1:0]                causeStage,
  output logic [RAIL_W-1:0]         causeRail
);
  logic [1:0]        topLevel;
  logic [RAIL_W-1:0] topRail;
  logic              escalate;

  // highest tripping stage; lowest rail index wins a tie
  always_comb begin
    topLevel = 2'd0;
    topRail  = '0;
    for (int r = NUM_RAILS - 1; r >= 0; r--) begin
      if (railTrip[r] >= topLevel) begin
        topLevel = railTrip[r];
        topRail  = RAIL_W'(r);
      end
    end
  end

  assign escalate       = topLevel > stage;
  assign evStrobe.fire  = escalate;
  assign evStrobe.stage = stage_e'(topLevel);
  assign evRail         = topRail;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage      <= STG_NORMAL;
      causeStage <= 2'd0;
      causeRail  <= '0;
    end else begin
      if (escalate)      stage <= stage_e'(topLevel);
      else if (allClear) stage <= STG_NORMAL;

      if (clearCause) begin
        causeStage <= escalate ? topLevel : 2'd0;
        causeRail  <= escalate ? topRail  : '0;
      end else if (escalate && topLevel > causeStage) begin
        causeStage <= topLevel;
        causeRail  <= topRail;
      end
    end
  end
endmodule

// File: rtl/bs_supervisor.sv
module bs_supervisor
  import bs_pkg::*;
#(
  parameter int NUM_RAILS  = 3,
  parameter int CODE_W     = 8,
  parameter int WARN_LEVEL = 200,
  parameter int DEG_LEVEL  = 180,
  parameter int RST_LEVEL  = 160,
  parameter int HYST       = 10,
  parameter int WARN_DEB   = 3,
  parameter int DEG_DEB    = 4,
  parameter int RST_DEB    = 5,
  parameter int STAMP_W    = 16,
  parameter int CNT_W      = 8,
  localparam int RAIL_W    = (NUM_RAILS > 1) ? $clog2(NUM_RAILS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_RAILS*CODE_W-1:0] railCode,
  input  logic                        clearCause,
  output logic                        logFlushReq,
  output logic                        timeDegraded,
  output logic                        resetReq,
  output logic [1:0]                  causeStage,
  output logic [RAIL_W-1:0]           causeRail,
  output logic                        eventValid,
  output logic [RAIL_W-1:0]           eventRail,
  output logic [1:0]                  eventStage,
  output logic [STAMP_W-1:0]          eventStamp,
  output logic [CNT_W-1:0]            eventCount,
  output logic [NUM_RAILS*CODE_W-1:0] railMin,
  output logic [NUM_RAILS*CODE_W-1:0] railMax
);
  evStrobe_t                 evStrobe;
  logic [RAIL_W-1:0]         evRail;
  logic [NUM_RAILS-1:0][1:0] railTrip;
  logic                      allClear;
  stage_e                    stage;

  bs_datapath #(
    .NUM_RAILS(NUM_RAILS), .CODE_W(CODE_W), .WARN_LEVEL(WARN_LEVEL),
    .DEG_LEVEL(DEG_LEVEL), .RST_LEVEL(RST_LEVEL), .HYST(HYST),
    .WARN_DEB(WARN_DEB), .DEG_DEB(DEG_DEB), .RST_DEB(RST_DEB),
    .STAMP_W(STAMP_W), .CNT_W(CNT_W), .RAIL_W(RAIL_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .railCode(railCode), .evStrobe(evStrobe),
    .evRail(evRail), .railTrip(railTrip), .allClear(allClear),
    .eventValid(eventValid), .eventRail(eventRail), .eventStage(eventStage),
    .eventStamp(eventStamp), .eventCount(eventCount),
    .railMin(railMin), .railMax(railMax)
  );

  bs_control #(.NUM_RAILS(NUM_RAILS), .RAIL_W(RAIL_W)) u_control (
    .clk(clk), .rstN(rstN), .railTrip(railTrip), .allClear(allClear),
    .clearCause(clearCause), .evStrobe(evStrobe), .evRail(evRail),
    .stage(stage), .causeStage(causeStage), .causeRail(causeRail)
  );

  assign logFlushReq  = stage != STG_NORMAL;
  assign timeDegraded = stage >= STG_DEGRADE;
  assign resetReq     = stage == STG_RESET;
endmodule

// File: rtl/bs_supervisor_chk.sv
module bs_supervisor_chk #(
  parameter int NUM_RAILS = 3,
  parameter int CODE_W    = 8,
  parameter int CNT_W     = 8
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        clearCause,
  input logic                        logFlushReq,
  input logic                        timeDegraded,
  input logic                        resetReq,
  input logic [1:0]                  causeStage,
  input logic                        eventValid,
  input logic [1:0]                  eventStage,
  input logic [CNT_W-1:0]            eventCount,
  input logic [NUM_RAILS*CODE_W-1:0] railMin,
  input logic [NUM_RAILS*CODE_W-1:0] railMax
);
  // R4
  reset_nests_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> (timeDegraded && logFlushReq));

  // R4
  reset_rise_event_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(resetReq) |-> (eventValid && eventStage == 2'd3));

  // R7
  event_stage_chk: assert property (@(posedge clk) disable iff (!rstN)
    eventValid |-> (eventStage != 2'd0));

  // R6
  drop_to_normal_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(timeDegraded) |-> !logFlushReq);

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (eventCount != $past(eventCount)) |-> (eventCount == $past(eventCount) + 1'b1));

  // R9
  cause_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(clearCause) |-> (causeStage >= $past(causeStage)));

  for (genvar r = 0; r < NUM_RAILS; r++) begin : g_ext
    // R10
    min_falls_chk: assert property (@(posedge clk) disable iff (!rstN)
      railMin[r*CODE_W +: CODE_W] <= $past(railMin[r*CODE_W +: CODE_W]));
    // R10
    max_rises_chk: assert property (@(posedge clk) disable iff (!rstN)
      railMax[r*CODE_W +: CODE_W] >= $past(railMax[r*CODE_W +: CODE_W]));
  end
endmodule

bind bs_supervisor bs_supervisor_chk #(
  .NUM_RAILS(NUM_RAILS), .CODE_W(CODE_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .clearCause(clearCause), .logFlushReq(logFlushReq),
  .timeDegraded(timeDegraded), .resetReq(resetReq), .causeStage(causeStage),
  .eventValid(eventValid), .eventStage(eventStage), .eventCount(eventCount),
  .railMin(railMin), .railMax(railMax)
);

// File: tb/bs_supervisor_bench.sv
module bs_supervisor_bench;
  localparam int NR = 3;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NR*CW-1:0] railCode;
  logic clearCause = 1'b0;
  logic logFlushReq, timeDegraded, resetReq, eventValid;
  logic [1:0] causeStage, eventStage, causeRail, eventRail;
  logic [15:0] eventStamp;
  logic [7:0] eventCount;
  logic [NR*CW-1:0] railMin, railMax;

  int checks = 0;
  int fails = 0;
  int edgeCnt = 0;
  bit done = 1'b0;
  logic [7:0] expMin [NR];
  logic [7:0] expMax [NR];

  always #2 clk = ~clk;

  bs_supervisor u_bs_supervisor (
    .clk(clk), .rstN(rstN), .railCode(railCode), .clearCause(clearCause),
    .logFlushReq(logFlushReq), .timeDegraded(timeDegraded), .resetReq(resetReq),
    .causeStage(causeStage), .causeRail(causeRail), .eventValid(eventValid),
    .eventRail(eventRail), .eventStage(eventStage), .eventStamp(eventStamp),
    .eventCount(eventCount), .railMin(railMin), .railMax(railMax)
  );

  // bench model: edge count and per-rail extremes
  always @(posedge clk) begin
    if (rstN) begin
      edgeCnt <= edgeCnt + 1;
      for (int r = 0; r < NR; r++) begin
        if (railCode[r*CW +: CW] < expMin[r]) expMin[r] <= railCode[r*CW +: CW];
        if (railCode[r*CW +: CW] > expMax[r]) expMax[r] <= railCode[r*CW +: CW];
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setRails(input int a, input int b, input int c);
    railCode = {8'(c), 8'(b), 8'(a)};
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chkStage(input string req, input int s);
    chk({req, " flush"},    32'(logFlushReq),  32'(s >= 1));
    chk({req, " degraded"}, 32'(timeDegraded), 32'(s >= 2));
    chk({req, " reset"},    32'(resetReq),     32'(s == 3));
  endtask

  task automatic chkEvent(input string req, input int rail, input int st);
    chk({req, " eventValid"}, 32'(eventValid), 1);
    chk({req, " eventRail"},  32'(eventRail),  32'(rail));
    chk({req, " eventStage"}, 32'(eventStage), 32'(st));
    chk({req, " eventStamp"}, 32'(eventStamp), 32'(edgeCnt - 1));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < NR; r++) begin expMin[r] = 8'hFF; expMax[r] = 8'h00; end
    setRails(230, 230, 230);
    repeat (3) tick();
    // R1 reset state
    chkStage("R1", 0);
    chk("R1 eventValid", 32'(eventValid), 0);
    chk("R1 causeStage", 32'(causeStage), 0);
    chk("R1 eventCount", 32'(eventCount), 0);
    chk("R1 railMin", 32'(railMin), 32'hFFFFFF);
    chk("R1 railMax", 32'(railMax), 0);
    rstN = 1'b1;
    tick();
    chk("R10 min after first sample", 32'(railMin[7:0]), 230);

    // R2 short dip on rail0 is filtered
    setRails(190, 230, 230);
    tick(); chkStage("R2 dip1", 0);
    tick(); chkStage("R2 dip2", 0);
    setRails(230, 230, 230);
    tick(); chkStage("R2 dip over", 0);
    chk("R2 no event", 32'(eventCount), 0);

    // R2 warn trip on rail1
    setRails(230, 195, 230);
    tick(); tick(); chkStage("R2 before window", 0);
    tick(); chkStage("R2 warn", 1);
    chkEvent("R7 warn", 1, 1);
    chk("R8 count", 32'(eventCount), 1);
    chk("R9 cause stage", 32'(causeStage), 1);
    chk("R9 cause rail", 32'(causeRail), 1);
    tick(); chk("R7 single pulse", 32'(eventValid), 0);

    // R6 hysteresis band
    setRails(230, 205, 230);
    repeat (4) tick();
    chkStage("R6 inside band", 1);
    setRails(230, 210, 230);
    tick(); chkStage("R6 cleared", 0);

    // R3 degrade on rail2
    setRails(230, 230, 170);
    tick(); tick(); tick();
    chkEvent("R7 degrade path warn", 2, 1);
    tick(); chkStage("R3 degrade", 2);
    chkEvent("R3 degrade event", 2, 2);
    chk("R8 count", 32'(eventCount), 3);
    tick(); chkStage("R3 holds above reset level", 2);

    // R5 no step down, no lower-stage event
    setRails(195, 230, 190);
    repeat (4) tick();
    chkStage("R5 held", 2);
    chk("R5 count unchanged", 32'(eventCount), 3);
    setRails(230, 230, 230);
    tick(); chkStage("R6 back to normal", 0);

    // R4 reset stage; tie between rail0 and rail2
    setRails(150, 230, 150);
    tick(); tick(); tick();
    chkEvent("R7 tie warn", 0, 1);
    tick(); chkEvent("R7 tie degrade", 0, 2);
    chkStage("R4 not yet", 2);
    tick(); chkStage("R4 reset", 3);
    chkEvent("R4 reset event", 0, 3);
    chk("R8 count", 32'(eventCount), 6);
    chk("R9 cause stage", 32'(causeStage), 3);
    chk("R9 cause rail", 32'(causeRail), 0);
    setRails(230, 230, 230);
    tick(); chkStage("R6 recovered from reset", 0);

    // R11 low samples spread across rails
    setRails(150, 230, 230); tick(); tick();
    setRails(230, 150, 230); tick(); tick();
    setRails(230, 230, 150); tick(); tick();
    setRails(230, 230, 230); tick();
    chkStage("R11 split dips", 0);
    chk("R11 no event", 32'(eventCount), 6);

    // R9 cause hold, clear, concurrent clear
    chk("R9 cause held", 32'(causeStage), 3);
    clearCause = 1'b1; tick(); clearCause = 1'b0;
    chk("R9 cleared", 32'(causeStage), 0);
    setRails(230, 170, 230);
    tick(); tick(); tick();
    chk("R9 new warn cause", 32'(causeStage), 1);
    chk("R9 new warn rail", 32'(causeRail), 1);
    clearCause = 1'b1; tick(); clearCause = 1'b0;
    chk("R9 clear with escalation", 32'(causeStage), 2);
    chk("R9 clear with escalation rail", 32'(causeRail), 1);
    tick();
    chk("R9 holds after", 32'(causeStage), 2);
    setRails(230, 230, 230);
    tick(); chkStage("R6 normal", 0);

    // R8 saturation
    chk("R8 count", 32'(eventCount), 8);
    for (int i = 0; i < 260; i++) begin
      setRails(195, 230, 230); tick(); tick(); tick();
      setRails(230, 230, 230); tick();
      if (i == 0) chk("R8 step", 32'(eventCount), 9);
    end
    chk("R8 saturated", 32'(eventCount), 255);

    // R10 extremes against bench model
    for (int r = 0; r < NR; r++) begin
      chk("R10 railMin", 32'(railMin[r*CW +: CW]), 32'(expMin[r]));
      chk("R10 railMax", 32'(railMax[r*CW +: CW]), 32'(expMax[r]));
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule